// File: doc/BRIEF.md
# Dual-Channel External Interrupt Controller

The controller watches two active-low external interrupt pins and turns their activity into two CPU interrupt requests and one wake-up signal. Each pin is brought into the clock domain through a two-flop synchroniser. A falling edge is found by comparing the synchronised sample with the sample one cycle older. Each channel has a mode bit. In edge mode, a falling edge sets a request that stays set until software acknowledges it. In level mode, the request is also held for as long as the pin stays low.

Software uses one 8-bit status and control register on a simple synchronous bus. Writes take effect at the clock edge, and the read data always shows the current state. In level mode, once the latched request has been acknowledged, the channel's flag shows the inverse of the synchronised pin. Software can therefore read the pin level through the flag while the channel is masked. The block stays clocked in the wait and stop standby modes. Any request that is not masked drives the wake-up output.

Top module: `ext_irq_pair`

## Requirements
- R1: A falling edge on a synchronised pin sets that channel's latched request in either mode. The channel's flag then reads 1 (bit 0 for channel 1, bit 4 for channel 2).
- R2: Writing 1 to a channel's acknowledge bit (bit 3 for channel 1, bit 7 for channel 2) clears that channel's latched request. This applies when no edge arrives in the same cycle and the channel is not held low in level mode.
- R3: While the latched request is clear and the mode bit is 1 (bit 2 for channel 1, bit 6 for channel 2), the flag reads as the inverse of the synchronised pin.
- R4: In level mode, after a new falling edge the flag stays 1 after the pin returns high, until another acknowledge is written.
- R5: A mask bit of 1 (bit 1 for channel 1, bit 5 for channel 2) forces that channel's request output low. The flag keeps updating.
- R6: `wake_req` is high exactly when at least one channel has an unmasked flag set.
- R7: In level mode, an acknowledge written while the synchronised pin is low leaves the request set.
- R8: In edge mode, the latched request stays set after the pin returns high, until it is acknowledged.
- R9: A pin change reaches the synchroniser output after two clock edges. A falling edge sets the latched request at the third edge.
- R10: An acknowledge written in the same cycle that a falling edge is detected leaves the request set.
- R11: Reset clears both requests, sets both masks to 1 and both modes to 0, so the register reads 8'h22. Acknowledge bits always read 0. Writes to the flag bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq1_pin_n | input | 1 | Channel 1 external pin, active low, asynchronous |
| irq2_pin_n | input | 1 | Channel 2 external pin, active low, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data |
| irq1_req | output | 1 | Channel 1 CPU interrupt request |
| irq2_req | output | 1 | Channel 2 CPU interrupt request |
| wake_req | output | 1 | Wake-up request for the standby modes |

## Verification
The hardest case to reach from the ports is an acknowledge write landing in the one cycle in which the edge detector sees a falling edge. That cycle sits three clock edges after the pin changes. The bench drops the pin, waits exactly two cycles, then holds the write strobe for one cycle so that it meets the detected edge. The level-mode sequence is also hard to reach: pin low, an acknowledge refused, the pin released, and then a second acknowledge that lets the flag follow the pin again. The bench steps through this in order while a behavioural model is compared against the outputs on every clock.

// File: rtl/ext_irq_pair.sv
module ext_irq_pair (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       irq1_pin_n,
  input  logic       irq2_pin_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq1_req,
  output logic       irq2_req,
  output logic       wake_req
);

  logic [1:0] meta, sync, prev;
  logic [1:0] latched, mask, mode;
  logic [1:0] fall, level, ack, flag, req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 2'b11;
      sync <= 2'b11;
      prev <= 2'b11;
    end else begin
      meta <= {irq2_pin_n, irq1_pin_n};
      sync <= meta;
      prev <= sync;
    end
  end

  assign fall  = prev & ~sync;
  assign level = mode & ~sync;
  assign ack   = wr_en ? {wr_data[7], wr_data[3]} : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= 2'b11;
      mode <= 2'b00;
    end else if (wr_en) begin
      mask <= {wr_data[5], wr_data[1]};
      mode <= {wr_data[6], wr_data[2]};
    end
  end

  for (genvar i = 0; i < 2; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        latched[i] <= 1'b0;
      else if (fall[i])
        latched[i] <= 1'b1;
      else if (ack[i] && !level[i])
        latched[i] <= 1'b0;
    end

    assert_edge_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fall[i] |=> latched[i]);
    assert_ack_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && !fall[i] && !level[i]) |=> !latched[i]);
    assert_low_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (latched[i] && level[i]) |=> latched[i]);
    assert_edge_persists_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (latched[i] && !mode[i] && !ack[i]) |=> latched[i]);
    assert_edge_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack[i] && fall[i]) |=> latched[i]);
  end

  assign flag = latched | level;
  assign req  = flag & ~mask;

  assign irq1_req = req[0];
  assign irq2_req = req[1];
  assign wake_req = |req;

  assign rd_data = {1'b0, mode[1], mask[1], flag[1], 1'b0, mode[0], mask[0], flag[0]};

endmodule

// File: tb/ext_irq_pair_tb.sv
`timescale 1ns/1ps
module ext_irq_pair_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       p1 = 1'b1, p2 = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq1_req, irq2_req, wake_req;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_pair u_dut (
    .clk(clk), .rst_n(rst_n), .irq1_pin_n(p1), .irq2_pin_n(p2),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq1_req(irq1_req), .irq2_req(irq2_req), .wake_req(wake_req)
  );

  // behavioural reference: pin history per channel, oldest at index 2
  int hist [2][3];
  int m_lat [2];
  int m_mask [2];
  int m_mode [2];

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int k = 0; k < 3; k++) hist[c][k] = 1;
      m_lat[c] = 0; m_mask[c] = 1; m_mode[c] = 0;
    end
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      for (int c = 0; c < 2; c++) begin
        int pin_now, seen_low, edge_seen, ackc;
        pin_now   = (c == 0) ? int'(p1) : int'(p2);
        seen_low  = (hist[c][1] == 0);
        edge_seen = (hist[c][2] == 1) && seen_low;
        ackc      = wr_en && wr_data[3 + 4*c];
        if (edge_seen) m_lat[c] = 1;
        else if (ackc && !(m_mode[c] && seen_low)) m_lat[c] = 0;
        hist[c][2] = hist[c][1];
        hist[c][1] = hist[c][0];
        hist[c][0] = pin_now;
        if (wr_en) begin
          m_mask[c] = int'(wr_data[1 + 4*c]);
          m_mode[c] = int'(wr_data[2 + 4*c]);
        end
      end
    end
  end

  function automatic int exp_flag(int c);
    return (m_lat[c] || (m_mode[c] && hist[c][1] == 0)) ? 1 : 0;
  endfunction

  function automatic logic [7:0] exp_rd();
    logic [7:0] v;
    v = 8'h00;
    for (int c = 0; c < 2; c++) begin
      v[4*c]     = exp_flag(c)[0];
      v[4*c + 1] = m_mask[c][0];
      v[4*c + 2] = m_mode[c][0];
    end
    return v;
  endfunction

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e1, e2;
      e1 = exp_flag(0) && !m_mask[0];
      e2 = exp_flag(1) && !m_mask[1];
      chk("R3/R11 model rd_data", int'(rd_data), int'(exp_rd()));
      chk("R5 model irq1_req", int'(irq1_req), e1);
      chk("R5 model irq2_req", int'(irq2_req), e2);
      chk("R6 model wake_req", int'(wake_req), (e1 || e2) ? 1 : 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = 8'h00;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R11 reset rd_data", int'(rd_data), 'h22);
    chk("R11 reset wake", int'(wake_req), 0);

    wr(8'h33);
    chk("R11 flag bits ignore write", int'(rd_data), 'h22);

    // edge mode, channel 1
    wr(8'h00);
    p1 = 1'b0;
    step(2);
    chk("R9 flag not yet set", int'(rd_data[0]), 0);
    step(1);
    chk("R1 edge sets flag", int'(rd_data[0]), 1);
    chk("R1 irq1 raised", int'(irq1_req), 1);
    chk("R6 wake raised", int'(wake_req), 1);
    p1 = 1'b1;
    step(4);
    chk("R8 request persists", int'(irq1_req), 1);
    wr(8'h08);
    chk("R2 ack clears flag", int'(rd_data[0]), 0);
    chk("R11 ack reads zero", int'(rd_data[3]), 0);
    chk("R6 wake cleared", int'(wake_req), 0);

    // ack coinciding with edge detect, channel 2
    p2 = 1'b0;
    step(2);
    wr(8'h80);
    chk("R10 edge wins over ack", int'(rd_data[4]), 1);
    chk("R10 irq2 kept", int'(irq2_req), 1);
    p2 = 1'b1;
    step(3);
    wr(8'h80);
    chk("R2 ack clears channel 2", int'(irq2_req), 0);

    // level mode, channel 1
    wr(8'h04);
    chk("R3 pin high flag low", int'(rd_data[0]), 0);
    p1 = 1'b0;
    step(2);
    chk("R3 flag is inverse pin", int'(rd_data[0]), 1);
    step(2);
    wr(8'h0C);
    chk("R7 ack while low refused", int'(rd_data[0]), 1);
    chk("R7 irq1 held", int'(irq1_req), 1);
    p1 = 1'b1;
    step(3);
    chk("R4 flag held after release", int'(rd_data[0]), 1);
    wr(8'h0C);
    chk("R3 flag tracks pin after ack", int'(rd_data[0]), 0);

    // masked level mode
    wr(8'h06);
    p1 = 1'b0;
    step(3);
    chk("R5 flag updates while masked", int'(rd_data[0]), 1);
    chk("R5 irq1 suppressed", int'(irq1_req), 0);
    chk("R6 wake suppressed", int'(wake_req), 0);
    p1 = 1'b1;
    step(3);
    wr(8'h0E);
    chk("R3 masked flag follows pin high", int'(rd_data[0]), 0);
    p1 = 1'b0;
    step(2);
    chk("R3 masked flag follows pin low", int'(rd_data[0]), 1);
    p1 = 1'b1;
    step(4);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule